// File: doc/BRIEF.md
# Tick-Paced I2C Transaction Master

This block is a single-master I2C controller. It accepts one command at a time (write, read, or a write followed by a read joined by a repeated start) and carries it out on the two open-drain bus lines. It only advances the bus on a one-cycle strobe `tick`. Outside logic produces that strobe at twice the wanted SCL frequency, so one SCL period takes two ticks. Each line is shown as a pull-low enable (`scl_oe`, `sda_oe`: 1 pulls the line low, 0 releases it). The SDA level comes back through `sda_in`.

Write bytes are taken one at a time through a valid/ready handshake, just before the first bit of each byte goes out. Read bytes come out as one-cycle pulses. Each command ends with exactly one result pulse: `done`, `err_nack` when the slave does not acknowledge a byte, or `err_inval` for a malformed request. The block does not support clock stretching, arbitration or 10-bit addresses.

Top module: `i2c_tick_master`

## Requirements
- R1: After reset and while idle, both lines are released (`scl_oe`=0, `sda_oe`=0), `busy` is 0 and `cmd_ready` is 1.
- R2: Each bus step lasts one tick. A start takes 3 ticks, every byte including its acknowledge slot takes 18 ticks, and a stop takes 2 ticks. `scl_oe` changes only in the cycle after a tick or after a write-data handshake.
- R3: The address byte is `{cmd_addr, rw}`, with rw=0 for a write phase and rw=1 for a read phase. It is sent MSB first.
- R4: Each write byte is fetched by one `wr_valid`/`wr_ready` handshake while SCL is held low. The bytes are sent in fetch order, MSB first.
- R5: A high SDA level in an acknowledge slot ends the command with a one-cycle `err_nack` pulse. Both lines are released, no stop is sent, and the block returns to idle.
- R6: Read bytes are assembled MSB first and each is given on `rd_data` with a one-cycle `rd_valid` pulse. The master pulls SDA low in the acknowledge slot of every read byte except the last, leaves it released for the last, and then sends a stop.
- R7: A write-read sends the address with rw=0 and the write bytes, then a repeated start, then the address with rw=1 and the read bytes. The slave sees two starts and one stop.
- R8: A write (`cmd_op`=01) with `cmd_wlen`=0 or a read (`cmd_op`=10) with `cmd_rlen`=0 pulses `done` in the cycle after acceptance. `busy` never rises and the lines do not move.
- R9: A write-read (`cmd_op`=11) with either length zero, or `cmd_op`=00, pulses `err_inval` in the cycle after acceptance, with no bus activity.
- R10: `busy` is high from the cycle after acceptance until the result pulse, and `cmd_ready` is high only when not busy. Exactly one of `done`, `err_nack` or `err_inval` pulses per accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Step strobe, twice the SCL rate |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 2 | 01 write, 10 read, 11 write-read, 00 invalid |
| cmd_addr | input | 7 | Slave address |
| cmd_wlen | input | LEN_W | Bytes to write |
| cmd_rlen | input | LEN_W | Bytes to read |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Engine wants the next write byte |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte pulse |
| rd_data | output | 8 | Read byte, valid with rd_valid |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished without error |
| err_nack | output | 1 | Slave did not acknowledge |
| err_inval | output | 1 | Request rejected |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA level |

## Verification
The acknowledge sample of the last write byte in a write-read falls on the same tick where the engine would otherwise turn to the repeated start. The same holds for the acknowledge of the second address, which would hand over to the read phase. A bus model of the slave is told to refuse exactly that byte. The bench then checks the following: `err_nack` appears instead of `done`, the slave sees no extra start or any stop, the tick count stops at the refused slot, and no read byte is delivered. Zero-length and rejected requests go through the same acceptance path and are judged by result pulses, a busy count of zero and unchanged line enables.

// File: rtl/i2cm_pkg.sv
// Shared constants and types of the tick-paced I2C master.
// Assumes byte-oriented I2C with 7-bit addressing.
package i2cm_pkg;
    localparam int BYTE_BITS = 8;
    localparam int ADDR_BITS = 7;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_WRRD  = 2'b11
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_ST0, S_ST1, S_ST2,
        S_WREQ, S_WBH, S_WBL, S_AKH, S_AKL,
        S_RBH, S_RBL, S_MAH, S_MAL,
        S_SP0, S_SP1
    } phase_e;
endpackage

// File: rtl/i2cm_sync.sv
// Multi-flop synchroniser for an asynchronous line level.
// Assumes STAGES >= 2; resets to RST_VAL (released line reads high).
module i2cm_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cm_shift.sv
// Byte shift register shared by transmit and receive, MSB first.
// Assumes load has priority over shift; sin enters at bit 0.
module i2cm_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] q
);
    // Load a new byte or move one bit towards the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (load)  q <= load_val;
        else if (shift) q <= {q[W-2:0], sin};
    end
endmodule

// File: rtl/i2c_tick_master.sv
// Single-master I2C transaction engine stepped by an external tick
// running at twice the SCL rate. Runs write, read and write-then-read
// commands; aborts on a missing acknowledge. Assumes no clock
// stretching and no other master on the bus. Line outputs are
// pull-low enables; SDA is read back through a synchroniser.
module i2c_tick_master
    import i2cm_pkg::*;
#(
    parameter int LEN_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic [1:0]           cmd_op,
    input  logic [ADDR_BITS-1:0] cmd_addr,
    input  logic [LEN_W-1:0]     cmd_wlen,
    input  logic [LEN_W-1:0]     cmd_rlen,
    input  logic                 wr_valid,
    output logic                 wr_ready,
    input  logic [BYTE_BITS-1:0] wr_data,
    output logic                 rd_valid,
    output logic [BYTE_BITS-1:0] rd_data,
    output logic                 busy,
    output logic                 done,
    output logic                 err_nack,
    output logic                 err_inval,
    output logic                 scl_oe,
    output logic                 sda_oe,
    input  logic                 sda_in
);
    localparam int BCW = $clog2(BYTE_BITS);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(BYTE_BITS - 1);

    phase_e                 st;
    op_e                    op_q;
    op_e                    op_in;
    logic [ADDR_BITS-1:0]   addr_q;
    logic [LEN_W-1:0]       wleft;
    logic [LEN_W-1:0]       rleft;
    logic [BCW-1:0]         bcnt;
    logic                   is_addr;
    logic                   rd_phase;
    logic                   sda_s;
    logic                   bad_req;
    logic                   zero_plain;
    logic                   sh_load;
    logic                   sh_shift;
    logic [BYTE_BITS-1:0]   sh_val;
    logic [BYTE_BITS-1:0]   sh_q;

    i2cm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s)
    );

    i2cm_shift #(.W(BYTE_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(sh_val),
        .shift(sh_shift), .sin(sda_s), .q(sh_q)
    );

    // Classify an offered command.
    always_comb begin
        op_in      = op_e'(cmd_op);
        bad_req    = (op_in == OP_NONE) ||
                     (op_in == OP_WRRD && (cmd_wlen == '0 || cmd_rlen == '0));
        zero_plain = (op_in == OP_WRITE && cmd_wlen == '0) ||
                     (op_in == OP_READ  && cmd_rlen == '0);
    end

    // Shifter control: load address or write byte, shift on bit steps.
    always_comb begin
        sh_load  = (st == S_ST2 && tick) || (st == S_WREQ && wr_valid);
        sh_val   = (st == S_ST2) ? {addr_q, rd_phase} : wr_data;
        sh_shift = tick && ((st == S_WBL && bcnt != LAST_BIT) || st == S_RBH);
    end

    // Handshake and status outputs decoded from the phase.
    always_comb begin
        cmd_ready = (st == S_IDLE);
        busy      = (st != S_IDLE);
        wr_ready  = (st == S_WREQ);
        rd_data   = sh_q;
    end

    // Line enables for each phase (1 pulls the line low).
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        case (st)
            S_ST1, S_SP0: sda_oe = 1'b1;
            S_ST2, S_WREQ, S_WBL, S_AKL, S_MAL: begin
                scl_oe = 1'b1;
                sda_oe = 1'b1;
            end
            S_WBH:   sda_oe = !sh_q[BYTE_BITS-1];
            S_RBL:   scl_oe = 1'b1;
            S_MAH:   sda_oe = (rleft != '0);
            default: ;
        endcase
    end

    // Phase sequencer with byte and bit counters and result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            op_q      <= OP_NONE;
            addr_q    <= '0;
            wleft     <= '0;
            rleft     <= '0;
            bcnt      <= '0;
            is_addr   <= 1'b0;
            rd_phase  <= 1'b0;
            done      <= 1'b0;
            err_nack  <= 1'b0;
            err_inval <= 1'b0;
            rd_valid  <= 1'b0;
        end else begin
            done      <= 1'b0;
            err_nack  <= 1'b0;
            err_inval <= 1'b0;
            rd_valid  <= 1'b0;
            case (st)
                S_IDLE: if (cmd_valid) begin
                    op_q     <= op_in;
                    addr_q   <= cmd_addr;
                    wleft    <= cmd_wlen;
                    rleft    <= cmd_rlen;
                    rd_phase <= (op_in == OP_READ);
                    if (bad_req)         err_inval <= 1'b1;
                    else if (zero_plain) done      <= 1'b1;
                    else                 st        <= S_ST0;
                end
                S_ST0: if (tick) st <= S_ST1;
                S_ST1: if (tick) st <= S_ST2;
                S_ST2: if (tick) begin
                    is_addr <= 1'b1;
                    bcnt    <= '0;
                    st      <= S_WBH;
                end
                S_WREQ: if (wr_valid) begin
                    wleft <= wleft - 1'b1;
                    bcnt  <= '0;
                    st    <= S_WBH;
                end
                S_WBH: if (tick) st <= S_WBL;
                S_WBL: if (tick) begin
                    if (bcnt == LAST_BIT) st <= S_AKH;
                    else begin
                        bcnt <= bcnt + 1'b1;
                        st   <= S_WBH;
                    end
                end
                S_AKH: if (tick) begin
                    if (sda_s) begin
                        err_nack <= 1'b1;
                        st       <= S_IDLE;
                    end else st <= S_AKL;
                end
                S_AKL: if (tick) begin
                    if (is_addr) begin
                        is_addr <= 1'b0;
                        bcnt    <= '0;
                        st      <= rd_phase ? S_RBH : S_WREQ;
                    end else if (wleft != '0) st <= S_WREQ;
                    else if (op_q == OP_WRRD) begin
                        rd_phase <= 1'b1;
                        st       <= S_ST0;
                    end else st <= S_SP0;
                end
                S_RBH: if (tick) st <= S_RBL;
                S_RBL: if (tick) begin
                    if (bcnt == LAST_BIT) begin
                        rd_valid <= 1'b1;
                        rleft    <= rleft - 1'b1;
                        st       <= S_MAH;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                        st   <= S_RBH;
                    end
                end
                S_MAH: if (tick) st <= S_MAL;
                S_MAL: if (tick) begin
                    bcnt <= '0;
                    st   <= (rleft != '0) ? S_RBH : S_SP0;
                end
                S_SP0: if (tick) st <= S_SP1;
                S_SP1: if (tick) begin
                    done <= 1'b1;
                    st   <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // Idle engine leaves both lines released.
    assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe))
        else $error("R1 lines driven while idle");

    // SCL moves only after a tick or a write-data handshake.
    assert_scl_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scl_oe) |-> ($past(tick) || $past(wr_valid && wr_ready)))
        else $error("R2 SCL changed without a step");

    // SCL is held low while waiting for write data.
    assert_wait_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (scl_oe && busy))
        else $error("R4 SCL released while fetching data");

    // After a refused byte the lines are free and the engine idle.
    assert_nack_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_nack |-> (!scl_oe && !sda_oe && cmd_ready))
        else $error("R5 lines not released after nack");

    // Read strobe lasts a single cycle.
    assert_rd_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid)
        else $error("R6 read strobe longer than one cycle");

    // Rejected requests come straight from acceptance.
    assert_inval_direct_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_inval |-> $past(cmd_valid && cmd_ready))
        else $error("R9 reject not tied to acceptance");

    // At most one result pulse, and none while still busy.
    assert_one_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({done, err_nack, err_inval}) <= 1 &&
        ((done || err_nack || err_inval) -> !busy))
        else $error("R10 result pulses overlap");

    // Ready and busy are exclusive.
    assert_ready_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready != busy)
        else $error("R10 ready and busy disagree");
endmodule

// File: tb/tb_i2c_tick_master.sv
module tb_i2c_tick_master;
    localparam int LEN_W = 4;
    localparam int TDIV  = 4;

    function automatic logic [7:0] wd(input int i);
        return 8'h3C + 8'(i * 89);
    endfunction
    function automatic logic [7:0] td(input int i);
        return 8'hC5 ^ 8'(i * 29);
    endfunction

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [6:0] cmd_addr = '0;
    logic [LEN_W-1:0] cmd_wlen = '0;
    logic [LEN_W-1:0] cmd_rlen = '0;
    logic wr_valid = 1'b1;
    logic [7:0] wr_data;
    logic cmd_ready, wr_ready, rd_valid, busy, done, err_nack, err_inval;
    logic scl_oe, sda_oe;
    logic [7:0] rd_data;
    logic s_oe = 1'b0;
    logic sda_line;

    int wr_idx = 0;
    bit take = 1'b0;
    int tcnt = 0;
    int checks = 0;
    int errors = 0;

    // monitor state
    int ticks, lchg, busyc, rdn, ndone, nnack, ninv;
    logic p_scl_oe = 1'b0, p_sda_oe = 1'b0;
    logic [7:0] rdlog [0:15];

    // slave state
    int k = 0, rxn = 0, txn = 0, starts = 0, stops = 0, nack_at = -1;
    bit tx = 1'b0, is_adr = 1'b0, ackit = 1'b0, p_scl = 1'b1, p_sda = 1'b1;
    logic [7:0] sreg = '0;
    logic [7:0] rxlog [0:15];
    logic mack [0:15];

    always #5 clk = ~clk;

    assign wr_data  = wd(wr_idx);
    assign sda_line = !(sda_oe || s_oe);

    i2c_tick_master #(.LEN_W(LEN_W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wlen(cmd_wlen), .cmd_rlen(cmd_rlen),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .done(done), .err_nack(err_nack), .err_inval(err_inval),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line)
    );

    // Tick source, write-data supplier and transaction monitor.
    always @(negedge clk) begin
        if (take) wr_idx++;
        take = wr_ready;
        tcnt = (tcnt == TDIV - 1) ? 0 : tcnt + 1;
        tick = (tcnt == 0);
        if (cmd_valid && cmd_ready) begin
            wr_idx = 0; ticks = 0; lchg = 0; busyc = 0;
            rdn = 0; ndone = 0; nnack = 0; ninv = 0;
        end else begin
            if (tick && busy) ticks++;
            if (scl_oe != p_scl_oe || sda_oe != p_sda_oe) lchg++;
            if (busy) busyc++;
            if (rd_valid) begin
                if (rdn < 16) rdlog[rdn] = rd_data;
                rdn++;
            end
            if (done) ndone++;
            if (err_nack) nnack++;
            if (err_inval) ninv++;
        end
        p_scl_oe = scl_oe;
        p_sda_oe = sda_oe;
    end

    // Behavioural slave on the wired bus.
    always @(negedge clk) begin : slave
        bit sc, sd;
        logic [7:0] tb;
        sc = !scl_oe;
        sd = !(sda_oe || s_oe);
        if (cmd_valid && cmd_ready) begin
            rxn = 0; txn = 0; starts = 0; stops = 0;
        end
        if (p_scl && sc && p_sda && !sd) begin
            starts++; k = 0; tx = 0; is_adr = 1; s_oe = 0;
        end else if (p_scl && sc && !p_sda && sd) begin
            stops++; k = 0; tx = 0; s_oe = 0;
        end else if (!p_scl && sc) begin
            if (tx) begin
                if (k == 8 && txn < 16) mack[txn] = sd;
                k++;
            end else begin
                if (k < 8) sreg = {sreg[6:0], sd};
                k++;
            end
        end else if (p_scl && !sc) begin
            if (tx) begin
                if (k < 8) begin
                    tb = td(txn);
                    s_oe = !tb[7-k];
                end else if (k == 8) s_oe = 0;
                else if (k == 9) begin
                    if (!mack[txn]) begin
                        txn++; k = 0; tb = td(txn); s_oe = !tb[7];
                    end else s_oe = 0;
                end
            end else begin
                if (k == 8) begin
                    if (rxn < 16) rxlog[rxn] = sreg;
                    ackit = (rxn != nack_at);
                    s_oe = ackit;
                    rxn++;
                end else if (k == 9) begin
                    s_oe = 0; k = 0;
                    if (is_adr && sreg[0] && ackit) begin
                        tx = 1; tb = td(txn); s_oe = !tb[7];
                    end
                    is_adr = 0;
                end
            end
        end
        p_scl = sc;
        p_sda = sd;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [1:0] op, input int w, input int r, input int nk,
                       input logic [6:0] a);
        int kind, et, erx, erd, est, esp, cyc, last_rx;
        logic [7:0] eb;
        nack_at = nk;
        // expectations from the requirements
        if (op == 2'b00 || (op == 2'b11 && (w == 0 || r == 0))) begin
            kind = 2; et = 0; erx = 0; erd = 0; est = 0; esp = 0;
        end else if ((op == 2'b01 && w == 0) || (op == 2'b10 && r == 0)) begin
            kind = 0; et = 0; erx = 0; erd = 0; est = 0; esp = 0;
        end else begin
            last_rx = (op == 2'b01) ? w : (op == 2'b10) ? 0 : w + 1;
            if (nk >= 0 && nk <= last_rx) begin
                kind = 1;
                et = 3 + 18 * nk + 17 + ((op == 2'b11 && nk == w + 1) ? 3 : 0);
                erx = nk + 1; erd = 0; esp = 0;
                est = (op == 2'b11 && nk == w + 1) ? 2 : 1;
            end else begin
                kind = 0;
                erx = last_rx + 1;
                erd = (op == 2'b01) ? 0 : r;
                est = (op == 2'b11) ? 2 : 1;
                esp = 1;
                et = (op == 2'b01) ? 23 + 18 * w :
                     (op == 2'b10) ? 23 + 18 * r : 44 + 18 * (w + r);
            end
        end
        // issue the command
        @(posedge clk); #1;
        cmd_valid = 1; cmd_op = op; cmd_addr = a;
        cmd_wlen = LEN_W'(w); cmd_rlen = LEN_W'(r);
        @(posedge clk); #1;
        cmd_valid = 0;
        cyc = 0;
        while (ndone + nnack + ninv == 0 && cyc < 8000) begin
            @(negedge clk); #1;
            cyc++;
        end
        repeat (3) @(negedge clk);
        #1;
        chk("R10", "result pulses total", ndone + nnack + ninv, 1);
        chk(kind == 1 ? "R5" : (kind == 2 ? "R9" : "R10"), "done count", ndone, kind == 0 ? 1 : 0);
        chk("R5", "nack count", nnack, kind == 1 ? 1 : 0);
        chk("R9", "inval count", ninv, kind == 2 ? 1 : 0);
        chk("R2", "ticks used", ticks, et);
        chk("R7", "starts seen", starts, est);
        chk("R5", "stops seen", stops, esp);
        chk("R1", "idle after command", {busy, scl_oe, sda_oe, cmd_ready}, 4'b0001);
        if (et == 0) begin
            chk("R8", "line changes", lchg, 0);
            chk("R8", "busy cycles", busyc, 0);
        end else chk("R10", "busy cycles nonzero", int'(busyc > 0), 1);
        chk("R4", "bytes seen by slave", rxn, erx);
        for (int i = 0; i < erx && i < 16; i++) begin
            if (i == 0) eb = {a, op == 2'b10};
            else if (op == 2'b11 && i == w + 1) eb = {a, 1'b1};
            else eb = wd(i - 1);
            chk((i == 0 || (op == 2'b11 && i == w + 1)) ? "R3" : "R4",
                "slave byte", rxlog[i], eb);
        end
        chk("R6", "bytes read", rdn, erd);
        for (int i = 0; i < erd && i < 16; i++) begin
            chk("R6", "read byte", rdlog[i], td(i));
            chk("R6", "master ack bit", mack[i], (i == erd - 1) ? 1 : 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk); #1;
        chk("R1", "reset state", {busy, scl_oe, sda_oe, cmd_ready}, 4'b0001);
        // plain writes incl. zero length (R8)
        for (int w = 0; w < 4; w++) run(2'b01, w, 0, -1, 7'h5A ^ 7'(w));
        // plain reads incl. zero length; wlen ignored on reads (R6)
        for (int r = 0; r < 4; r++) run(2'b10, 3, r, -1, 7'h21 + 7'(r));
        // combined write-read sweep (R7)
        for (int w = 1; w < 4; w++)
            for (int r = 1; r < 4; r++) run(2'b11, w, r, -1, 7'h40 + 7'(w * 4 + r));
        // rejected requests (R9)
        run(2'b11, 0, 2, -1, 7'h12);
        run(2'b11, 2, 0, -1, 7'h13);
        run(2'b00, 1, 1, -1, 7'h14);
        // refusals (R5) at address, mid data, read address,
        // last write byte before repeated start, second address
        run(2'b01, 2, 0, 0, 7'h7F);
        run(2'b01, 3, 0, 2, 7'h00);
        run(2'b10, 0, 2, 0, 7'h33);
        run(2'b11, 2, 2, 2, 7'h55);
        run(2'b11, 2, 2, 3, 7'h2A);
        // recovery after an abort
        run(2'b01, 1, 0, -1, 7'h66);
        run(2'b10, 0, 0, -1, 7'h67);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule